// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home node of a small distributed shared-memory system. It owns a set of coherence blocks. For every block it keeps a directory entry and a copy of the block's data. The entry holds a state (invalid, shared or exclusive), a copyset bitmask of the nodes that hold a valid copy, and the identity of the exclusive owner. Requester nodes send read-miss or write-miss requests. The home answers each one in one of three ways: it replies from its own storage, it forwards the request to the current owner, or it invalidates the sharers and then grants exclusivity.

Every message travels on its own valid/ready channel and carries a node ID and a block index. Outgoing channels are the reply to the requester, the forward to the owner and the invalidation. Incoming channels are the request, the invalidation acknowledgement and the owner's writeback. The controller runs one transaction at a time. While a transaction is open, new requests are held off by a low ready, so requests to any one block are always serialized.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is invalid, `req_ready` is 1 and `rsp_valid`, `fwd_valid` and `inv_valid` are 0. The home data of block k equals k truncated to the data width.
- R2: A read miss (`req_write`=0) to an invalid block is answered with a reply carrying the home data and `rsp_excl`=0. Afterwards the copyset holds only the requester.
- R3: A write miss (`req_write`=1) to an invalid block is answered with a reply carrying the home data and `rsp_excl`=1. The requester becomes the owner.
- R4: A read miss to a shared block is answered with a reply carrying the home data and `rsp_excl`=0. The requester is added to the copyset and the existing members stay.
- R5: A read miss to an exclusive block sends a forward to the owner with `fwd_req_node` set to the requester and `fwd_write`=0. The home sends no reply of its own. Only a writeback from that owner for that block is accepted. Its data replaces the home data, and the block becomes shared by the owner and the requester.
- R6: A write miss to an exclusive block sends a forward to the owner with `fwd_write`=1. After the owner's writeback, the requester is recorded as owner and is the only member of the copyset.
- R7: A write miss to a shared block sends one invalidation to each copyset member other than the requester, in ascending node index. The block then becomes exclusive to the requester. If the requester is the only member, no invalidation is sent and the grant follows at once.
- R8: In a write miss to a shared block, the reply with `rsp_excl`=1 is not presented until as many acknowledgements have been accepted as invalidations were sent. An acknowledgement naming another block is refused with `ack_ready`=0.
- R9: `req_ready` is 0 from the cycle after a request is accepted until its transaction completes.
- R10: A reply, forward or invalidation that is presented but not yet accepted stays valid with unchanged fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Request accepted when high with valid |
| req_node | input | NID_W | Requesting node |
| req_blk | input | BID_W | Requested block |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| rsp_valid | output | 1 | Reply from home present |
| rsp_ready | input | 1 | Reply accepted |
| rsp_node | output | NID_W | Node the reply goes to |
| rsp_blk | output | BID_W | Block of the reply |
| rsp_data | output | DATA_W | Home data of the block |
| rsp_excl | output | 1 | 1 = exclusive grant, 0 = shared copy |
| fwd_valid | output | 1 | Forward to owner present |
| fwd_ready | input | 1 | Forward accepted |
| fwd_node | output | NID_W | Current owner |
| fwd_blk | output | BID_W | Forwarded block |
| fwd_req_node | output | NID_W | Node the owner must serve |
| fwd_write | output | 1 | 1 = transfer ownership, 0 = share |
| inv_valid | output | 1 | Invalidation present |
| inv_ready | input | 1 | Invalidation accepted |
| inv_node | output | NID_W | Sharer to invalidate |
| inv_blk | output | BID_W | Block to invalidate |
| ack_valid | input | 1 | Invalidation acknowledgement present |
| ack_ready | output | 1 | Acknowledgement accepted |
| ack_blk | input | BID_W | Block being acknowledged |
| wb_valid | input | 1 | Owner writeback present |
| wb_ready | output | 1 | Writeback accepted |
| wb_node | input | NID_W | Node sending the writeback |
| wb_blk | input | BID_W | Block written back |
| wb_data | input | DATA_W | Current block data from the owner |

## Verification
The bench walks every block through long chains of misses from nodes that rotate with the block index. Even blocks run reads, sole-sharer upgrades, forwarded reads, growing copysets and three-sharer invalidation rounds. Odd blocks start with a write to an invalid block, so ownership is handed on before any sharer exists. The invalidation sets that follow show whether earlier steps built the copyset correctly: they reveal a requester that was dropped, an owner that was left out after a forwarded read, or a member that was kept after an upgrade. Writeback data that changes from step to step separates a reply taken from home storage from one taken from stale data. Held-off replies and forwards, and acknowledgements that name the wrong block, test the handshake rules apart from the protocol.

// File: rtl/hdir_pkg.sv
package hdir_pkg;
   typedef enum logic [1:0] {
      BS_INV = 2'd0,
      BS_SH  = 2'd1,
      BS_EX  = 2'd2
   } bstate_t;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_REPLY = 3'd1,
      PH_FWD   = 3'd2,
      PH_WB    = 3'd3,
      PH_INV   = 3'd4
   } phase_t;
endpackage

// File: rtl/hdir_popcnt.sv
module hdir_popcnt #(
   parameter int W     = 4,
   parameter int CNT_W = 3
) (
   input  logic [W-1:0]     vec,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] acc [W+1];

   assign acc[0] = '0;
   for (genvar g = 0; g < W; g++) begin : g_add
      assign acc[g+1] = acc[g] + CNT_W'(vec[g]);
   end
   assign cnt = acc[W];
endmodule

// File: rtl/hdir_lowbit.sv
module hdir_lowbit #(
   parameter int W  = 4,
   parameter int IW = 2
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/hdir_entry.sv
module hdir_entry
   import hdir_pkg::*;
#(
   parameter int                  NODES    = 4,
   parameter int                  NID_W    = 2,
   parameter int                  DATA_W   = 8,
   parameter logic [DATA_W-1:0]   RST_DATA = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              dwe,
   input  bstate_t           n_st,
   input  logic [NODES-1:0]  n_cs,
   input  logic [NID_W-1:0]  n_own,
   input  logic [DATA_W-1:0] n_data,
   output bstate_t           q_st,
   output logic [NODES-1:0]  q_cs,
   output logic [NID_W-1:0]  q_own,
   output logic [DATA_W-1:0] q_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_st   <= BS_INV;
         q_cs   <= '0;
         q_own  <= '0;
         q_data <= RST_DATA;
      end else begin
         if (we) begin
            q_st  <= n_st;
            q_cs  <= n_cs;
            q_own <= n_own;
         end
         if (dwe) q_data <= n_data;
      end
   end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
   import hdir_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int BLOCKS = 16,
   parameter int DATA_W = 8,
   localparam int NID_W = (NODES > 1) ? $clog2(NODES) : 1,
   localparam int BID_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [NID_W-1:0]  req_node,
   input  logic [BID_W-1:0]  req_blk,
   input  logic              req_write,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [NID_W-1:0]  rsp_node,
   output logic [BID_W-1:0]  rsp_blk,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_excl,
   output logic              fwd_valid,
   input  logic              fwd_ready,
   output logic [NID_W-1:0]  fwd_node,
   output logic [BID_W-1:0]  fwd_blk,
   output logic [NID_W-1:0]  fwd_req_node,
   output logic              fwd_write,
   output logic              inv_valid,
   input  logic              inv_ready,
   output logic [NID_W-1:0]  inv_node,
   output logic [BID_W-1:0]  inv_blk,
   input  logic              ack_valid,
   output logic              ack_ready,
   input  logic [BID_W-1:0]  ack_blk,
   input  logic              wb_valid,
   output logic              wb_ready,
   input  logic [NID_W-1:0]  wb_node,
   input  logic [BID_W-1:0]  wb_blk,
   input  logic [DATA_W-1:0] wb_data
);
   localparam int CNT_W = $clog2(NODES + 1);

   if (NODES < 2) begin : g_bad_nodes
      $error("home_dir_ctrl: NODES must be at least 2");
   end
   if (BLOCKS < 2 || (1 << BID_W) != BLOCKS) begin : g_bad_blocks
      $error("home_dir_ctrl: BLOCKS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("home_dir_ctrl: DATA_W must be positive");
   end

   // directory entries
   bstate_t           e_st   [BLOCKS];
   logic [NODES-1:0]  e_cs   [BLOCKS];
   logic [NID_W-1:0]  e_own  [BLOCKS];
   logic [DATA_W-1:0] e_data [BLOCKS];

   logic              u_we, u_dwe;
   logic [BID_W-1:0]  u_blk;
   bstate_t           u_st;
   logic [NODES-1:0]  u_cs;
   logic [NID_W-1:0]  u_own;
   logic [DATA_W-1:0] u_data;

   for (genvar b = 0; b < BLOCKS; b++) begin : g_ent
      hdir_entry #(
         .NODES(NODES), .NID_W(NID_W), .DATA_W(DATA_W),
         .RST_DATA(DATA_W'(b))
      ) ent_i (
         .clk(clk), .rst_n(rst_n),
         .we(u_we && (u_blk == BID_W'(b))),
         .dwe(u_dwe && (u_blk == BID_W'(b))),
         .n_st(u_st), .n_cs(u_cs), .n_own(u_own), .n_data(u_data),
         .q_st(e_st[b]), .q_cs(e_cs[b]), .q_own(e_own[b]), .q_data(e_data[b])
      );
   end

   // transaction registers
   phase_t            ph, ph_d;
   logic [NID_W-1:0]  cur_node, node_d;
   logic [BID_W-1:0]  cur_blk, blk_d;
   logic              cur_wr, wr_d;
   logic [NODES-1:0]  inv_pend, pend_d;
   logic [CNT_W-1:0]  ack_cnt, cnt_d;

   logic [NODES-1:0]  req_oh, cur_oh, own_oh, others;
   logic [CNT_W-1:0]  oth_cnt;
   logic [NID_W-1:0]  inv_pick;
   logic [NID_W-1:0]  own_cur;

   assign req_oh  = NODES'(1) << req_node;
   assign cur_oh  = NODES'(1) << cur_node;
   assign own_cur = e_own[cur_blk];
   assign own_oh  = NODES'(1) << own_cur;
   assign others  = e_cs[req_blk] & ~req_oh;

   hdir_popcnt #(.W(NODES), .CNT_W(CNT_W)) pc_i (.vec(others), .cnt(oth_cnt));
   hdir_lowbit #(.W(NODES), .IW(NID_W)) lb_i (.vec(inv_pend), .idx(inv_pick));

   assign req_ready    = (ph == PH_IDLE);
   assign rsp_valid    = (ph == PH_REPLY);
   assign rsp_node     = cur_node;
   assign rsp_blk      = cur_blk;
   assign rsp_data     = e_data[cur_blk];
   assign rsp_excl     = cur_wr;
   assign fwd_valid    = (ph == PH_FWD);
   assign fwd_node     = own_cur;
   assign fwd_blk      = cur_blk;
   assign fwd_req_node = cur_node;
   assign fwd_write    = cur_wr;
   assign inv_valid    = (ph == PH_INV) && (inv_pend != '0);
   assign inv_node     = inv_pick;
   assign inv_blk      = cur_blk;
   assign ack_ready    = (ph == PH_INV) && (ack_cnt != '0) && (ack_blk == cur_blk);
   assign wb_ready     = (ph == PH_WB) && (wb_blk == cur_blk) && (wb_node == own_cur);

   always_comb begin
      ph_d   = ph;
      node_d = cur_node;
      blk_d  = cur_blk;
      wr_d   = cur_wr;
      pend_d = inv_pend;
      cnt_d  = ack_cnt;
      u_we   = 1'b0;
      u_dwe  = 1'b0;
      u_blk  = cur_blk;
      u_st   = BS_INV;
      u_cs   = '0;
      u_own  = cur_node;
      u_data = wb_data;
      unique case (ph)
         PH_IDLE: begin
            if (req_valid) begin
               node_d = req_node;
               blk_d  = req_blk;
               wr_d   = req_write;
               u_blk  = req_blk;
               u_own  = req_node;
               unique case (e_st[req_blk])
                  BS_SH: begin
                     if (!req_write) begin
                        u_we  = 1'b1;
                        u_st  = BS_SH;
                        u_cs  = e_cs[req_blk] | req_oh;
                        u_own = e_own[req_blk];
                        ph_d  = PH_REPLY;
                     end else if (oth_cnt == '0) begin
                        u_we = 1'b1;
                        u_st = BS_EX;
                        u_cs = req_oh;
                        ph_d = PH_REPLY;
                     end else begin
                        pend_d = others;
                        cnt_d  = oth_cnt;
                        ph_d   = PH_INV;
                     end
                  end
                  BS_EX: ph_d = PH_FWD;
                  default: begin
                     u_we = 1'b1;
                     u_st = req_write ? BS_EX : BS_SH;
                     u_cs = req_oh;
                     ph_d = PH_REPLY;
                  end
               endcase
            end
         end
         PH_INV: begin
            if (inv_valid && inv_ready) pend_d[inv_pick] = 1'b0;
            if (ack_valid && ack_ready) cnt_d = ack_cnt - CNT_W'(1);
            if (inv_pend == '0 && ack_cnt == '0) begin
               u_we = 1'b1;
               u_st = BS_EX;
               u_cs = cur_oh;
               ph_d = PH_REPLY;
            end
         end
         PH_REPLY: if (rsp_ready) ph_d = PH_IDLE;
         PH_FWD:   if (fwd_ready) ph_d = PH_WB;
         PH_WB: begin
            if (wb_valid && wb_ready) begin
               u_we  = 1'b1;
               u_dwe = 1'b1;
               u_st  = cur_wr ? BS_EX : BS_SH;
               u_cs  = cur_wr ? cur_oh : (cur_oh | own_oh);
               u_own = cur_wr ? cur_node : own_cur;
               ph_d  = PH_IDLE;
            end
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         cur_node <= '0;
         cur_blk  <= '0;
         cur_wr   <= 1'b0;
         inv_pend <= '0;
         ack_cnt  <= '0;
      end else begin
         ph       <= ph_d;
         cur_node <= node_d;
         cur_blk  <= blk_d;
         cur_wr   <= wr_d;
         inv_pend <= pend_d;
         ack_cnt  <= cnt_d;
      end
   end
endmodule

// File: rtl/home_dir_ctrl_chk.sv
module home_dir_ctrl_chk #(
   parameter int NID_W  = 2,
   parameter int BID_W  = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [NID_W-1:0]  rsp_node,
   input logic [BID_W-1:0]  rsp_blk,
   input logic [DATA_W-1:0] rsp_data,
   input logic              rsp_excl,
   input logic              fwd_valid,
   input logic              fwd_ready,
   input logic [NID_W-1:0]  fwd_node,
   input logic [BID_W-1:0]  fwd_blk,
   input logic [NID_W-1:0]  fwd_req_node,
   input logic              fwd_write,
   input logic              inv_valid,
   input logic              inv_ready,
   input logic [NID_W-1:0]  inv_node,
   input logic [BID_W-1:0]  inv_blk,
   input logic              ack_valid,
   input logic              ack_ready
);
   logic [7:0] outst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outst <= '0;
      else outst <= outst + 8'(inv_valid && inv_ready) - 8'(ack_valid && ack_ready);
   end

   p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_node) && $stable(rsp_blk)
                                     && $stable(rsp_data) && $stable(rsp_excl)));

   p_fwd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_node) && $stable(fwd_blk)
                                     && $stable(fwd_req_node) && $stable(fwd_write)));

   p_inv_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_node) && $stable(inv_blk)));

   p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || fwd_valid || inv_valid) |-> !req_ready);

   p_single_msg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_valid, fwd_valid, inv_valid}));

   p_no_early_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (outst == 8'd0));

   p_inv_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_ready) |=> (!inv_valid || (inv_node > $past(inv_node))));
endmodule

bind home_dir_ctrl home_dir_ctrl_chk #(
   .NID_W(NID_W), .BID_W(BID_W), .DATA_W(DATA_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node),
   .rsp_blk(rsp_blk), .rsp_data(rsp_data), .rsp_excl(rsp_excl),
   .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_node(fwd_node),
   .fwd_blk(fwd_blk), .fwd_req_node(fwd_req_node), .fwd_write(fwd_write),
   .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node),
   .inv_blk(inv_blk), .ack_valid(ack_valid), .ack_ready(ack_ready)
);

// File: tb/home_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module home_dir_ctrl_tb_top;
   localparam int NODES = 4;
   localparam int BLOCKS = 16;
   localparam int DATA_W = 8;
   localparam int NID_W = 2;
   localparam int BID_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              req_valid = 0, req_ready, req_write = 0;
   logic [NID_W-1:0]  req_node = '0;
   logic [BID_W-1:0]  req_blk = '0;
   logic              rsp_valid, rsp_ready = 0, rsp_excl;
   logic [NID_W-1:0]  rsp_node;
   logic [BID_W-1:0]  rsp_blk;
   logic [DATA_W-1:0] rsp_data;
   logic              fwd_valid, fwd_ready = 0, fwd_write;
   logic [NID_W-1:0]  fwd_node, fwd_req_node;
   logic [BID_W-1:0]  fwd_blk;
   logic              inv_valid, inv_ready = 0;
   logic [NID_W-1:0]  inv_node;
   logic [BID_W-1:0]  inv_blk;
   logic              ack_valid = 0, ack_ready;
   logic [BID_W-1:0]  ack_blk = '0;
   logic              wb_valid = 0, wb_ready;
   logic [NID_W-1:0]  wb_node = '0;
   logic [BID_W-1:0]  wb_blk = '0;
   logic [DATA_W-1:0] wb_data = '0;

   home_dir_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
      .req_blk(req_blk), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node),
      .rsp_blk(rsp_blk), .rsp_data(rsp_data), .rsp_excl(rsp_excl),
      .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_node(fwd_node),
      .fwd_blk(fwd_blk), .fwd_req_node(fwd_req_node), .fwd_write(fwd_write),
      .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node),
      .inv_blk(inv_blk),
      .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_blk(ack_blk),
      .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_node(wb_node),
      .wb_blk(wb_blk), .wb_data(wb_data)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // reference model: 0 invalid, 1 shared, 2 exclusive
   int m_st [BLOCKS];
   int m_cs [BLOCKS];
   int m_own [BLOCKS];
   int m_data [BLOCKS];

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic wait_rsp(input int n, input int b, input int d, input int ex,
                           input string tag);
      int t = 0;
      while (!rsp_valid && t < 40) begin @(negedge clk); t++; end
      chk(rsp_valid, tag, "reply present", rsp_valid, 1);
      chk(rsp_node == n, tag, "reply node", rsp_node, n);
      chk(rsp_blk == b, tag, "reply block", rsp_blk, b);
      chk(rsp_data == d, tag, "reply data", rsp_data, d);
      chk(rsp_excl == ex, tag, "reply excl", rsp_excl, ex);
      @(negedge clk);
      chk(rsp_valid && rsp_data == d && rsp_node == n, "R10", "reply held", rsp_valid, 1);
      rsp_ready = 1;
      @(negedge clk);
      rsp_ready = 0;
   endtask

   task automatic send_ack(input int b);
      ack_valid = 1; ack_blk = BID_W'(b);
      #1;
      while (!ack_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      ack_valid = 0;
   endtask

   task automatic do_access(input int n, input int b, input bit wr, input int wbv);
      int t;
      int oth;
      int exp_n;
      req_valid = 1; req_node = NID_W'(n); req_blk = BID_W'(b); req_write = wr;
      chk(req_ready, "R9", "idle ready", req_ready, 1);
      @(negedge clk);
      req_valid = 0;
      chk(!req_ready, "R9", "busy stall", req_ready, 0);
      if (m_st[b] == 0) begin
         wait_rsp(n, b, m_data[b], wr, wr ? "R3" : "R2");
         m_st[b] = wr ? 2 : 1; m_cs[b] = 1 << n; m_own[b] = n;
      end else if (m_st[b] == 1 && !wr) begin
         wait_rsp(n, b, m_data[b], 0, "R4");
         m_cs[b] = m_cs[b] | (1 << n);
      end else if (m_st[b] == 1) begin
         oth = m_cs[b] & ~(1 << n);
         for (int k = 0; k < NODES; k++) begin
            if (oth[k]) begin
               t = 0;
               while (!inv_valid && t < 40) begin @(negedge clk); t++; end
               chk(inv_valid && inv_node == k, "R7", "invalidation node", inv_node, k);
               chk(inv_blk == b, "R7", "invalidation block", inv_blk, b);
               inv_ready = 1;
               @(negedge clk);
               inv_ready = 0;
            end
         end
         @(negedge clk);
         chk(!inv_valid, "R7", "no extra invalidation", inv_valid, 0);
         if (oth != 0) begin
            ack_valid = 1; ack_blk = BID_W'((b + 1) % BLOCKS);
            #1;
            chk(!ack_ready, "R8", "foreign ack refused", ack_ready, 0);
            ack_valid = 0;
         end
         for (int k = 0; k < NODES; k++) begin
            if (oth[k]) begin
               chk(!rsp_valid, "R8", "grant before last ack", rsp_valid, 0);
               send_ack(b);
            end
         end
         wait_rsp(n, b, m_data[b], 1, "R8");
         m_st[b] = 2; m_cs[b] = 1 << n; m_own[b] = n;
      end else begin
         exp_n = m_own[b];
         t = 0;
         while (!fwd_valid && t < 40) begin @(negedge clk); t++; end
         chk(fwd_valid && fwd_node == exp_n, wr ? "R6" : "R5", "forward owner", fwd_node, exp_n);
         chk(fwd_req_node == n, wr ? "R6" : "R5", "forward requester", fwd_req_node, n);
         chk(fwd_write == wr && fwd_blk == b, wr ? "R6" : "R5", "forward kind", fwd_write, wr);
         @(negedge clk);
         chk(fwd_valid && fwd_node == exp_n, "R10", "forward held", fwd_valid, 1);
         fwd_ready = 1;
         @(negedge clk);
         fwd_ready = 0;
         wb_valid = 1; wb_node = NID_W'((exp_n + 1) % NODES); wb_blk = BID_W'(b);
         wb_data = DATA_W'(wbv);
         #1;
         chk(!wb_ready, "R5", "writeback from non-owner refused", wb_ready, 0);
         wb_node = NID_W'(exp_n);
         #1;
         while (!wb_ready) begin @(negedge clk); #1; end
         @(negedge clk);
         wb_valid = 0;
         chk(!rsp_valid, wr ? "R6" : "R5", "no home reply", rsp_valid, 0);
         @(negedge clk);
         chk(!rsp_valid && req_ready, wr ? "R6" : "R5", "done after writeback", req_ready, 1);
         m_data[b] = wbv & 255;
         if (wr) begin m_st[b] = 2; m_cs[b] = 1 << n; m_own[b] = n; end
         else begin m_st[b] = 1; m_cs[b] = (1 << exp_n) | (1 << n); end
      end
   endtask

   initial begin
      for (int b = 0; b < BLOCKS; b++) begin
         m_st[b] = 0; m_cs[b] = 0; m_own[b] = 0; m_data[b] = b;
      end
      repeat (3) @(negedge clk);
      chk(req_ready && !rsp_valid && !fwd_valid && !inv_valid, "R1", "reset outputs", req_ready, 1);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !fwd_valid && !inv_valid, "R1", "idle after reset", req_ready, 1);
      for (int b = 0; b < BLOCKS; b++) begin
         int a = b % NODES;
         int c = (b + 1) % NODES;
         int d = (b + 2) % NODES;
         int e = (b + 3) % NODES;
         if (b % 2 == 0) begin
            do_access(a, b, 0, 0);            // R1 R2 home data equals block index
            do_access(a, b, 1, 0);            // R7 sole sharer upgrade
            do_access(c, b, 0, b * 16 + 1);   // R5
            do_access(d, b, 1, 0);            // R7 two sharers
            do_access(e, b, 0, b * 16 + 2);   // R5
            do_access(a, b, 0, 0);            // R4
            do_access(c, b, 1, 0);            // R7 three sharers
            do_access(d, b, 1, b * 16 + 3);   // R6
         end else begin
            do_access(a, b, 1, 0);            // R3
            do_access(c, b, 1, b * 16 + 4);   // R6
            do_access(d, b, 0, b * 16 + 5);   // R5
            do_access(e, b, 0, 0);            // R4
            do_access(a, b, 1, 0);            // R7 R8
            do_access(c, b, 0, b * 16 + 6);   // R5
         end
      end
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule